// File: doc/BRIEF.md
# Three-Colour LED Strobe and Current-PWM Controller

This block runs the illumination side of a colour-sequential light engine. It steps a red, green and blue enable strobe in a fixed rotation, one colour at a time. Each colour holds for a programmable number of clock cycles. Alongside the strobes it produces three free-running 8-bit PWM outputs, one per colour. The duty value of each PWM sets the average current of that LED. A master driver-enable output is high whenever the illumination is allowed to run. All outputs are timed from the single oscillator clock.

Two asynchronous inputs act as a hard safety override: a fault flag and an external LED enable. Each passes through a two-stage synchroniser. While the fault is high or the enable is low, the driver enable, every strobe and every PWM output are held low.

The colour sequencer keeps counting while the override is in force. Once the override is released, the outputs stay dark until the sequencer next wraps from blue to red, so illumination always resumes with a complete red phase.

The block has two state machines. The phase sequencer has states PH_RED, PH_GRN and PH_BLU, with transitions RED→GRN, GRN→BLU and BLU→RED, each taken when the dwell count of the current colour expires. The gate machine has states GT_BLOCKED and GT_LIVE. It goes from BLOCKED to LIVE when the override is clear and the sequencer wraps from blue to red. It goes from LIVE to BLOCKED as soon as the synchronised override appears.

Top module: `led_illum_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until the first blue-to-red wrap with the enable high and the fault low, drv_on, all strobes and all PWM outputs are low.
- R2: The strobes fire one at a time in the order red, green, blue, then red again, with each colour starting in the cycle after the previous one ends.
- R3: Each strobe stays high for exactly its dwell value in clock cycles; a dwell of 0 behaves as 1.
- R4: While running, drv_on stays high through every strobe pulse, and exactly one strobe is high in every cycle that drv_on is high.
- R5: In any 256 consecutive running cycles a PWM output is high for exactly its duty value (0 to 255): duty 0 never goes high, and duty 255 is high in 255 of 256 cycles. A new duty value is taken when that channel's counter wraps.
- R6: A fault input set up before a rising edge forces drv_on, all strobes and all PWM outputs low by the second rising edge after it, and keeps them low while the fault is held.
- R7: A low LED enable input forces the same outputs low with the same two-edge latency.
- R8: After the override is released, all outputs stay low until the next blue-to-red wrap of the free-running sequencer. The first phase shown is then a complete red phase, with strobe_r and drv_on rising together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| fault_in | input | 1 | Asynchronous LED fault flag, active high |
| led_en_in | input | 1 | Asynchronous LED enable, active high |
| duty_r | input | PW | Red PWM duty value |
| duty_g | input | PW | Green PWM duty value |
| duty_b | input | PW | Blue PWM duty value |
| dwell_r | input | DW | Red phase length in cycles |
| dwell_g | input | DW | Green phase length in cycles |
| dwell_b | input | DW | Blue phase length in cycles |
| drv_on | output | 1 | Master LED driver enable |
| strobe_r | output | 1 | Red enable strobe |
| strobe_g | output | 1 | Green enable strobe |
| strobe_b | output | 1 | Blue enable strobe |
| pwm_r | output | 1 | Red current PWM |
| pwm_g | output | 1 | Green current PWM |
| pwm_b | output | 1 | Blue current PWM |

## Verification
The sequence is tried with an uneven dwell set (3, 5, 2) and with a set that holds a zero dwell (1, 0, 4). This separates an ordering fault from a length fault, and it exposes wrong handling of a zero dwell. The PWM outputs are measured over a full period with the extreme duties 0 and 255 next to a midpoint, and then with small, odd and large values. This shows whether the comparison or the period length is off.

The fault is raised just as green begins and is released while the sequencer is still in green or blue. A design that wakes up straight away, rather than at the next red, therefore shows a non-red first phase. The enable override is tried on its own during a blue phase.

// File: rtl/led_illum_pkg.sv
package led_illum_pkg;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_t;

    typedef enum logic {
        GT_BLOCKED = 1'b0,
        GT_LIVE    = 1'b1
    } gate_t;

    localparam int NUM_COLOURS = 3;

endpackage

// File: rtl/led_sync.sv
module led_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain <= {STAGES{RST_VAL}};
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/led_pwm_chan.sv
module led_pwm_chan #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] duty,
    output logic          pwm_o
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] duty_q;
    logic          wrap;

    assign wrap = (cnt == {CW{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            duty_q <= '0;
        end else begin
            cnt <= cnt + 1'b1;
            if (wrap)
                duty_q <= duty;
        end
    end

    always_comb begin
        pwm_o = (cnt < duty_q);
    end

    // R5: a zero duty never produces a high output
    a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |-> !pwm_o);

    // R5: a duty change only takes hold across a counter wrap
    a_r5_duty_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wrap) |-> $stable(duty_q));

endmodule

// File: rtl/led_phase_seq.sv
module led_phase_seq
    import led_illum_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] dwell_r,
    input  logic [DW-1:0] dwell_g,
    input  logic [DW-1:0] dwell_b,
    output phase_t        phase,
    output logic          cyc_start
);
    phase_t        nxt;
    logic [DW-1:0] cnt;
    logic [DW-1:0] dwell_cur;
    logic          last;

    always_comb begin
        unique case (phase)
            PH_RED:  dwell_cur = dwell_r;
            PH_GRN:  dwell_cur = dwell_g;
            PH_BLU:  dwell_cur = dwell_b;
            default: dwell_cur = dwell_r;
        endcase
        last = ({1'b0, cnt} + 1'b1) >= {1'b0, dwell_cur};
    end

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_RED:  if (last) nxt = PH_GRN;
            PH_GRN:  if (last) nxt = PH_BLU;
            PH_BLU:  if (last) nxt = PH_RED;
            default: nxt = PH_RED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_RED;
            cnt   <= '0;
        end else begin
            phase <= nxt;
            cnt   <= last ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        cyc_start = (phase == PH_BLU) && last;
    end

    // R2: red is always followed by green
    a_r2_red_to_grn: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_RED && phase != PH_RED) |-> phase == PH_GRN);

    // R2: green is always followed by blue
    a_r2_grn_to_blu: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_GRN && phase != PH_GRN) |-> phase == PH_BLU);

    // R3: a phase is held until its dwell count expires
    a_r3_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(phase));

endmodule

// File: rtl/led_gate.sv
module led_gate
    import led_illum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ok,
    input  logic cyc_start,
    output logic live
);
    gate_t st;
    gate_t nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            GT_BLOCKED: if (ok && cyc_start) nxt = GT_LIVE;
            GT_LIVE:    if (!ok)             nxt = GT_BLOCKED;
            default:    nxt = GT_BLOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= GT_BLOCKED;
        else
            st <= nxt;
    end

    always_comb begin
        live = (st == GT_LIVE) && ok;
    end

    // R8: the gate opens only on a blue-to-red wrap
    a_r8_open_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == GT_BLOCKED && st == GT_LIVE) |-> $past(cyc_start));

    // R6: a lost override condition closes the gate at once
    a_r6_close: assert property (@(posedge clk) disable iff (!rst_n)
        !ok |-> !live);

endmodule

// File: rtl/led_illum_ctrl.sv
module led_illum_ctrl
    import led_illum_pkg::*;
#(
    parameter int DW          = 8,
    parameter int PW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fault_in,
    input  logic          led_en_in,
    input  logic [PW-1:0] duty_r,
    input  logic [PW-1:0] duty_g,
    input  logic [PW-1:0] duty_b,
    input  logic [DW-1:0] dwell_r,
    input  logic [DW-1:0] dwell_g,
    input  logic [DW-1:0] dwell_b,
    output logic          drv_on,
    output logic          strobe_r,
    output logic          strobe_g,
    output logic          strobe_b,
    output logic          pwm_r,
    output logic          pwm_g,
    output logic          pwm_b
);
    logic                   fault_s;
    logic                   en_s;
    logic                   ok;
    logic                   live;
    logic                   cyc_start;
    phase_t                 phase;
    logic [NUM_COLOURS-1:0] pwm_raw;
    logic [PW-1:0]          duty_arr [NUM_COLOURS];

    led_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_fault (
        .clk(clk), .rst_n(rst_n), .d(fault_in), .q(fault_s)
    );

    led_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_en (
        .clk(clk), .rst_n(rst_n), .d(led_en_in), .q(en_s)
    );

    assign ok = en_s && !fault_s;

    led_phase_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .dwell_r(dwell_r), .dwell_g(dwell_g), .dwell_b(dwell_b),
        .phase(phase), .cyc_start(cyc_start)
    );

    led_gate u_gate (
        .clk(clk), .rst_n(rst_n), .ok(ok), .cyc_start(cyc_start), .live(live)
    );

    always_comb begin
        duty_arr[0] = duty_r;
        duty_arr[1] = duty_g;
        duty_arr[2] = duty_b;
    end

    for (genvar gi = 0; gi < NUM_COLOURS; gi++) begin : g_pwm
        led_pwm_chan #(.CW(PW)) u_pwm (
            .clk(clk), .rst_n(rst_n), .duty(duty_arr[gi]), .pwm_o(pwm_raw[gi])
        );
    end

    always_comb begin
        drv_on   = live;
        strobe_r = live && (phase == PH_RED);
        strobe_g = live && (phase == PH_GRN);
        strobe_b = live && (phase == PH_BLU);
        pwm_r    = live && pwm_raw[0];
        pwm_g    = live && pwm_raw[1];
        pwm_b    = live && pwm_raw[2];
    end

    // R2: never two strobes at once
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({strobe_r, strobe_g, strobe_b}));

    // R4: while the driver is on, exactly one strobe is active
    a_r4_drv_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        drv_on |-> $countones({strobe_r, strobe_g, strobe_b}) == 1);

    // R6: a synchronised fault darkens every output
    a_r6_fault_dark: assert property (@(posedge clk) disable iff (!rst_n)
        fault_s |-> !(drv_on || strobe_r || strobe_g || strobe_b || pwm_r || pwm_g || pwm_b));

    // R7: a synchronised low enable darkens every output
    a_r7_enable_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |-> !(drv_on || strobe_r || strobe_g || strobe_b || pwm_r || pwm_g || pwm_b));

    // R8: illumination resumes with red
    a_r8_red_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_on) |-> strobe_r);

endmodule

// File: tb/led_illum_ctrl_test.sv
`timescale 1ns/1ps
module led_illum_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fault_in = 1'b0;
    logic       led_en_in = 1'b0;
    logic [7:0] duty_r = '0, duty_g = '0, duty_b = '0;
    logic [7:0] dwell_r = 8'd4, dwell_g = 8'd4, dwell_b = 8'd4;
    logic       drv_on, strobe_r, strobe_g, strobe_b, pwm_r, pwm_g, pwm_b;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    int exp_q[$];

    always #2 clk = ~clk;

    led_illum_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .led_en_in(led_en_in),
        .duty_r(duty_r), .duty_g(duty_g), .duty_b(duty_b),
        .dwell_r(dwell_r), .dwell_g(dwell_g), .dwell_b(dwell_b),
        .drv_on(drv_on), .strobe_r(strobe_r), .strobe_g(strobe_g), .strobe_b(strobe_b),
        .pwm_r(pwm_r), .pwm_g(pwm_g), .pwm_b(pwm_b)
    );

    task automatic check(input bit good, input string req, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int all_out();
        return {drv_on, strobe_r, strobe_g, strobe_b, pwm_r, pwm_g, pwm_b};
    endfunction

    // driver: queue expected pulses (colour code 0=red 1=green 2=blue)
    task automatic push_seq(input int lr, input int lg, input int lb, input int reps);
        for (int i = 0; i < reps; i++) begin
            exp_q.push_back((0 << 16) | lr);
            exp_q.push_back((1 << 16) | lg);
            exp_q.push_back((2 << 16) | lb);
        end
    endtask

    task automatic run_seq(input int dr, input int dg, input int db);
        dwell_r = dr[7:0]; dwell_g = dg[7:0]; dwell_b = db[7:0];
        push_seq((dr == 0) ? 1 : dr, (dg == 0) ? 1 : dg, (db == 0) ? 1 : db, 2);
        led_en_in = 1'b1;
        while (exp_q.size() > 0) @(negedge clk);
        led_en_in = 1'b0;
        repeat (4) @(negedge clk);
        check(all_out() == 0, "R7 dark after enable drop", all_out(), 0);
    endtask

    task automatic measure_pwm(input int er, input int eg, input int eb);
        int cr = 0, cg = 0, cb = 0;
        repeat (520) @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            cr += pwm_r; cg += pwm_g; cb += pwm_b;
            @(negedge clk);
        end
        check(cr == er, "R5 red duty", cr, er);
        check(cg == eg, "R5 green duty", cg, eg);
        check(cb == eb, "R5 blue duty", cb, eb);
    endtask

    // monitor: measure strobe pulses and compare against queued items
    logic [2:0] prev_s = '0;
    int         cur_len = 0;
    bit         drv_held = 1'b1;
    always @(negedge clk) begin
        logic [2:0] s;
        int item, act_c;
        if (!rst_n) begin
            prev_s = '0; cur_len = 0; drv_held = 1'b1;
        end else begin
            s = {strobe_b, strobe_g, strobe_r};
            if ($countones(s) > 1) check(1'b0, "R2 single strobe", $countones(s), 1);
            if (s != prev_s) begin
                if (prev_s != 0 && exp_q.size() > 0) begin
                    item  = exp_q.pop_front();
                    act_c = (prev_s == 3'b001) ? 0 : (prev_s == 3'b010) ? 1 :
                            (prev_s == 3'b100) ? 2 : 7;
                    check(act_c == (item >> 16), "R2 colour order", act_c, item >> 16);
                    check(cur_len == (item & 16'hFFFF), "R3 pulse length", cur_len, item & 16'hFFFF);
                    check(drv_held, "R4 drv_on through pulse", drv_held, 1);
                end
                cur_len  = (s != 0) ? 1 : 0;
                drv_held = drv_on;
            end else if (s != 0) begin
                cur_len++;
                if (!drv_on) drv_held = 1'b0;
            end
            prev_s = s;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int n, len;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(all_out() == 0, "R1 reset outputs", all_out(), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(all_out() == 0, "R1 dark with enable low", all_out(), 0);

        run_seq(3, 5, 2);
        run_seq(1, 0, 4);

        // PWM duties
        dwell_r = 8'd10; dwell_g = 8'd10; dwell_b = 8'd10;
        duty_r = 8'd0; duty_g = 8'd255; duty_b = 8'd128;
        led_en_in = 1'b1;
        n = 0;
        while (!drv_on && n < 500) begin @(negedge clk); n++; end
        measure_pwm(0, 255, 128);
        duty_r = 8'd1; duty_g = 8'd37; duty_b = 8'd200;
        measure_pwm(1, 37, 200);

        // fault override raised as green begins
        @(negedge clk);
        while (!strobe_g) @(negedge clk);
        fault_in = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(all_out() == 0, "R6 dark by second edge", all_out(), 0);
        repeat (5) @(negedge clk);
        check(all_out() == 0, "R6 dark while held", all_out(), 0);
        fault_in = 1'b0;
        n = 0;
        while (all_out() == 0 && n < 400) begin @(negedge clk); n++; end
        check(strobe_r && drv_on && !strobe_g && !strobe_b, "R8 resume on red",
              {strobe_r, strobe_g, strobe_b}, 4);
        len = 0;
        while (strobe_r && len < 100) begin len++; @(negedge clk); end
        check(len == 10, "R8 full red phase", len, 10);

        // enable override during blue
        while (!strobe_b) @(negedge clk);
        led_en_in = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(all_out() == 0, "R7 dark by second edge", all_out(), 0);
        repeat (30) @(negedge clk);
        check(all_out() == 0, "R7 dark while low", all_out(), 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule